// File: doc/BRIEF.md
# Frame Memory Rectangle Transfer Sequencer

This block copies a rectangle of 16-bit pixels between a 32-bit word stream and a frame memory of 1024 by 512 pixels. The direction is picked at start. A start pulse loads a position word and a size word. The sequencer then walks the rectangle in row-major order and issues one pixel access per memory cycle. The memory port is simple and synchronous: one cycle of read latency, and one 16-bit pixel per access. Each stream word carries two pixels. The stream does not realign at the end of a row, so a word whose first pixel closes a row carries the first pixel of the next row.

For a transfer into memory, the producer offers words with a valid/ready handshake. It may pause between any two words, and the sequencer holds its column position inside the current row while it waits. For a transfer out of memory, the sequencer fetches the first two pixels straight after start and presents them in a read-data register. It raises a read-busy flag for the whole transfer. The consumer takes each word with a pop pulse, and that pop starts the fetch of the next word. A one-cycle done pulse marks the end of every transfer that runs to completion. A new start pulse abandons any transfer in progress.

Top module: `vram_xfer_seq`

## Requirements
- R1: Start X is taken from position-word bits 9:0 and start Y from bits 24:16 (9 bits). All other position-word bits have no effect on the addresses produced.
- R2: Width is ((size word - 1) mod 1024) + 1, taken from size bits 9:0. A field of 0 gives 1024 pixels and a field of 0x401 gives 1. Bits 15:10 and 31:25 have no effect.
- R3: Height is ((size bits 24:16) - 1) mod 512 + 1, so a field of 0 gives 512 rows.
- R4: Pixels are accessed in row-major order. The pixel in column c of row r goes to address (((Y + r) mod 512) * 1024 + X + c) mod 2^19. The column is not wrapped, so a row that passes X = 1023 spills into the next address.
- R5: In each stream word, bits 15:0 hold the earlier pixel (lower X) and bits 31:16 the next pixel. Packing runs on across row ends. When the pixel count is odd, the upper half of the final word is never written to memory, and on a read it is returned as zero.
- R6: During a write transfer, wr_ready is high whenever the sequencer waits for a word. Idle cycles between words leave the position inside the row unchanged.
- R7: A read start raises rd_busy on the next cycle. The first word, holding the pixels at the start position, is presented with rd_valid no later than the 4th cycle after the start edge. rd_valid is only high during a read.
- R8: done pulses for exactly one cycle once per completed transfer: after the last pixel write, or when the word holding the last pixel is popped. rd_busy falls at that same edge.
- R9: While reset is held, every output is low.
- R10: A memory read returns its data one cycle after the access. The sequencer makes exactly one access per rectangle pixel and none while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load setup words and begin a transfer |
| dir_read | input | 1 | Direction at start: 1 = memory to stream, 0 = stream to memory |
| pos_word | input | 32 | Start position word |
| size_word | input | 32 | Rectangle size word |
| wr_valid | input | 1 | Stream word offered for writing |
| wr_data | input | 32 | Stream word, two pixels |
| wr_ready | output | 1 | Sequencer accepts a stream word |
| rd_pop | input | 1 | Consumer takes the presented read word |
| rd_valid | output | 1 | rd_data holds a word for the consumer |
| rd_data | output | 32 | Read word, two pixels |
| rd_busy | output | 1 | A read transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 19 | Pixel address |
| mem_wdata | output | 16 | Pixel to write |
| mem_rdata | input | 16 | Pixel read, one cycle after the access |

## Verification
A corrupted column offset or row index shows up on the first memory access after the fault. Every access is checked against an address list computed from the setup words, so such a fault is caught within a cycle. A lost pixel half or a mis-packed word shows up on the next write data or the next presented read word. A wrong remaining-height count appears at the end of the transfer as a missing, extra or early access, or as a done pulse that does not arrive exactly once.

// File: rtl/vram_xfer_pkg.sv
// Shared types for the rectangle transfer sequencer.
// Assumes: one controller state machine uses the state type below.
package vram_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_WAIT,
        ST_W_LO,
        ST_W_HI,
        ST_R_LO,
        ST_R_HI,
        ST_R_CAP,
        ST_R_HOLD
    } xfer_state_t;

endpackage

// File: rtl/vram_xfer_decode.sv
// Setup decoder: turns the position and size words into a start corner and
// extents. Extents are stored minus one with wrap, so a zero field means the
// full dimension. Assumes the Y field starts at the middle of the word.
module vram_xfer_decode #(
    parameter int X_BITS = 10,
    parameter int Y_BITS = 9,
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] pos_word,
    input  logic [WORD_W-1:0] size_word,
    output logic [X_BITS-1:0] x_start,
    output logic [Y_BITS-1:0] y_start,
    output logic [X_BITS:0]   width,
    output logic [Y_BITS:0]   height
);
    localparam int HALF = WORD_W / 2;

    logic [X_BITS-1:0] w_m1;
    logic [Y_BITS-1:0] h_m1;
    logic              unused_bits;

    // Field extraction and minus-one-with-wrap decoding of the extents.
    always_comb begin
        x_start = pos_word[X_BITS-1:0];
        y_start = pos_word[HALF+Y_BITS-1:HALF];
        w_m1    = size_word[X_BITS-1:0] - X_BITS'(1);
        h_m1    = size_word[HALF+Y_BITS-1:HALF] - Y_BITS'(1);
        width   = (X_BITS+1)'(w_m1) + (X_BITS+1)'(1);
        height  = (Y_BITS+1)'(h_m1) + (Y_BITS+1)'(1);
    end

    assign unused_bits = ^{pos_word[WORD_W-1:HALF+Y_BITS], pos_word[HALF-1:X_BITS],
                           size_word[WORD_W-1:HALF+Y_BITS], size_word[HALF-1:X_BITS]};

endmodule

// File: rtl/vram_xfer_walk.sv
// Rectangle walker: holds the start column, current row, column offset and
// remaining rows, and advances one pixel per step. The address is
// row*2^X_BITS + start column + offset, truncated to the memory size.
// Assumes load and step are never needed in the same cycle (load wins).
module vram_xfer_walk #(
    parameter int X_BITS = 10,
    parameter int Y_BITS = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic [X_BITS-1:0]        x_start,
    input  logic [Y_BITS-1:0]        y_start,
    input  logic [X_BITS:0]          width,
    input  logic [Y_BITS:0]          height,
    output logic [X_BITS+Y_BITS-1:0] addr,
    output logic                     active,
    output logic                     last_pix
);
    localparam int ADDR_W = X_BITS + Y_BITS;

    logic [X_BITS-1:0] x_q;
    logic [Y_BITS-1:0] y_q;
    logic [X_BITS:0]   w_q;
    logic [Y_BITS:0]   h_q;
    logic [X_BITS-1:0] col_q;
    logic              row_end;

    // Position decode: end of row, end of rectangle, pixel address.
    always_comb begin
        row_end  = ({1'b0, col_q} == (w_q - (X_BITS+1)'(1)));
        active   = (h_q != '0);
        last_pix = active && row_end && (h_q == (Y_BITS+1)'(1));
        addr     = {y_q, {X_BITS{1'b0}}} + ADDR_W'(x_q) + ADDR_W'(col_q);
    end

    // Position state: load on start, advance column or row on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            w_q   <= '0;
            h_q   <= '0;
            col_q <= '0;
        end else if (load) begin
            x_q   <= x_start;
            y_q   <= y_start;
            w_q   <= width;
            h_q   <= height;
            col_q <= '0;
        end else if (step && active) begin
            if (row_end) begin
                col_q <= '0;
                y_q   <= y_q + Y_BITS'(1);
                h_q   <= h_q - (Y_BITS+1)'(1);
            end else begin
                col_q <= col_q + X_BITS'(1);
            end
        end
    end

    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ({1'b0, col_q} < w_q)); // R4

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && active && row_end && !load) |=>
            (col_q == '0 && y_q == Y_BITS'($past(y_q) + Y_BITS'(1)))); // R4

    AST_LOAD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active && col_q == '0)); // R3

endmodule

// File: rtl/vram_xfer_pack.sv
// Pixel packer: splits a held stream word into its two pixels for writing,
// and assembles two fetched pixels into the read-data register.
// Assumes the lower half is always the earlier pixel.
module vram_xfer_pack #(
    parameter int PIX_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_word,
    input  logic [2*PIX_W-1:0] word_in,
    input  logic               sel_hi,
    output logic [PIX_W-1:0]   pix_out,
    input  logic               cap_lo,
    input  logic               fin_hi,
    input  logic               fin_lo_only,
    input  logic [PIX_W-1:0]   pix_in,
    output logic [2*PIX_W-1:0] rd_word
);
    logic [2*PIX_W-1:0] word_q;
    logic [PIX_W-1:0]   lo_q;

    // Write side: pick the half that goes out this cycle.
    assign pix_out = sel_hi ? word_q[2*PIX_W-1:PIX_W] : word_q[PIX_W-1:0];

    // Word holder, low-pixel holder and read-data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            lo_q    <= '0;
            rd_word <= '0;
        end else begin
            if (load_word)   word_q  <= word_in;
            if (cap_lo)      lo_q    <= pix_in;
            if (fin_lo_only) rd_word <= {{PIX_W{1'b0}}, pix_in};
            else if (fin_hi) rd_word <= {pix_in, lo_q};
        end
    end

    AST_ODD_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fin_lo_only |=> (rd_word[2*PIX_W-1:PIX_W] == '0)); // R5

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_hi && !fin_lo_only) |=> (rd_word[PIX_W-1:0] == $past(lo_q))); // R5

endmodule

// File: rtl/vram_xfer_seq.sv
// Rectangle transfer sequencer top: decodes setup words, walks the rectangle
// and moves one pixel per memory cycle between the word stream and a
// frame memory with one cycle of read latency.
// Assumes a single-port memory; a new start abandons any transfer.
module vram_xfer_seq
    import vram_xfer_pkg::*;
#(
    parameter int X_BITS = 10,
    parameter int Y_BITS = 9,
    parameter int PIX_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     dir_read,
    input  logic [2*PIX_W-1:0]       pos_word,
    input  logic [2*PIX_W-1:0]       size_word,
    input  logic                     wr_valid,
    input  logic [2*PIX_W-1:0]       wr_data,
    output logic                     wr_ready,
    input  logic                     rd_pop,
    output logic                     rd_valid,
    output logic [2*PIX_W-1:0]       rd_data,
    output logic                     rd_busy,
    output logic                     done,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [X_BITS+Y_BITS-1:0] mem_addr,
    output logic [PIX_W-1:0]         mem_wdata,
    input  logic [PIX_W-1:0]         mem_rdata
);
    localparam int WORD_W = 2 * PIX_W;

    xfer_state_t       state;
    logic              lo_last_q;
    logic [X_BITS-1:0] x_start;
    logic [Y_BITS-1:0] y_start;
    logic [X_BITS:0]   width;
    logic [Y_BITS:0]   height;
    logic              walk_active;
    logic              walk_last;
    logic              step;
    logic              load_word;

    vram_xfer_decode #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .WORD_W(WORD_W)) u_decode (
        .pos_word (pos_word),
        .size_word(size_word),
        .x_start  (x_start),
        .y_start  (y_start),
        .width    (width),
        .height   (height)
    );

    vram_xfer_walk #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .step    (step),
        .x_start (x_start),
        .y_start (y_start),
        .width   (width),
        .height  (height),
        .addr    (mem_addr),
        .active  (walk_active),
        .last_pix(walk_last)
    );

    vram_xfer_pack #(.PIX_W(PIX_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_word  (load_word),
        .word_in    (wr_data),
        .sel_hi     (state == ST_W_HI),
        .pix_out    (mem_wdata),
        .cap_lo     (state == ST_R_HI),
        .fin_hi     (state == ST_R_CAP),
        .fin_lo_only(state == ST_R_HI && lo_last_q),
        .pix_in     (mem_rdata),
        .rd_word    (rd_data)
    );

    // Memory strobes and stream handshakes decoded from the state.
    always_comb begin
        mem_we    = (state == ST_W_LO) || (state == ST_W_HI);
        mem_en    = mem_we || (state == ST_R_LO) || (state == ST_R_HI && !lo_last_q);
        step      = mem_en;
        wr_ready  = (state == ST_W_WAIT);
        rd_valid  = (state == ST_R_HOLD);
        load_word = wr_ready && wr_valid && !start;
    end

    // Transfer control: start, per-word write pairs, per-word read fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rd_busy   <= 1'b0;
            done      <= 1'b0;
            lo_last_q <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state     <= dir_read ? ST_R_LO : ST_W_WAIT;
                rd_busy   <= dir_read;
                lo_last_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE:   state <= ST_IDLE;
                    ST_W_WAIT: if (wr_valid) state <= ST_W_LO;
                    ST_W_LO: begin
                        state <= walk_last ? ST_IDLE : ST_W_HI;
                        done  <= walk_last;
                    end
                    ST_W_HI: begin
                        state <= walk_last ? ST_IDLE : ST_W_WAIT;
                        done  <= walk_last;
                    end
                    ST_R_LO: begin
                        lo_last_q <= walk_last;
                        state     <= ST_R_HI;
                    end
                    ST_R_HI:   state <= lo_last_q ? ST_R_HOLD : ST_R_CAP;
                    ST_R_CAP:  state <= ST_R_HOLD;
                    ST_R_HOLD: begin
                        if (rd_pop) begin
                            if (!walk_active) begin
                                state   <= ST_IDLE;
                                rd_busy <= 1'b0;
                                done    <= 1'b1;
                            end else begin
                                state <= ST_R_LO;
                            end
                        end
                    end
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_MEM_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> walk_active); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_busy) |-> (done || $past(start))); // R8

    AST_RD_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_busy); // R7

    AST_WR_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !rd_busy); // R6

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dir_read) |=> rd_busy); // R7

endmodule

// File: tb/tb_vram_xfer_seq.sv
`timescale 1ns/1ps
module tb_vram_xfer_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_read = 1'b0;
    logic [31:0] pos_word = '0;
    logic [31:0] size_word = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        rd_pop = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_busy;
    logic        done;
    logic        mem_en;
    logic        mem_we;
    logic [18:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] rd_next = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int done_cnt = 0;
    int exp_addr[$];
    logic [15:0] exp_wpix[$];
    logic [15:0] bmem [int];

    always #2.5 clk = ~clk;

    vram_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_read(dir_read),
        .pos_word(pos_word), .size_word(size_word),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_busy(rd_busy), .done(done),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] mval(input int a);
        if (bmem.exists(a)) return bmem[a];
        return 16'(a) ^ 16'hA5C3;
    endfunction

    // Reference walk built from R2/R3/R4: row-major, rows mod 512, column unwrapped.
    task automatic plan(input int x0, input int y0, input int w, input int h);
        exp_addr.delete();
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                exp_addr.push_back((((y0 + r) % 512) * 1024 + x0 + c) % 524288);
    endtask

    // Behavioural memory and per-cycle access checker.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (mem_en) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R10", "access beyond rectangle", mem_addr, 0);
                end else begin
                    int a;
                    a = exp_addr.pop_front();
                    chk(mem_addr == 19'(a), "R4", "pixel address", mem_addr, a);
                    if (mem_we) begin
                        logic [15:0] p;
                        p = (exp_wpix.size() != 0) ? exp_wpix.pop_front() : 16'hxxxx;
                        chk(mem_wdata == p, "R5", "written pixel", mem_wdata, p);
                        bmem[int'(mem_addr)] = mem_wdata;
                    end else begin
                        rd_next = mval(int'(mem_addr));
                    end
                end
            end
        end
    end

    // One cycle of read latency (R10).
    always @(posedge clk) mem_rdata <= rd_next;

    task automatic start_xfer(input logic [31:0] pw, input logic [31:0] sw, input logic rd);
        @(posedge clk); #1;
        pos_word = pw; size_word = sw; dir_read = rd; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run_write(input string tag, input logic [31:0] pw, input logic [31:0] sw,
                             input int x0, input int y0, input int w, input int h,
                             input int gap, input int seed);
        logic [15:0] pv[$];
        int n;
        int nw;
        n = w * h;
        nw = (n + 1) / 2;
        plan(x0, y0, w, h);
        exp_wpix.delete();
        for (int i = 0; i < n; i++) begin
            pv.push_back(16'(i * 97 + seed));
            exp_wpix.push_back(16'(i * 97 + seed));
        end
        done_cnt = 0;
        start_xfer(pw, sw, 1'b0);
        for (int k = 0; k < nw; k++) begin
            if (gap > 0) begin
                repeat (gap) @(posedge clk);
                #1;
            end
            wr_data  = {(2 * k + 1 < n) ? pv[2 * k + 1] : 16'hDEAD, pv[2 * k]};
            wr_valid = 1'b1;
            forever begin
                @(negedge clk);
                if (wr_ready) break;
            end
            @(posedge clk); #1;
            wr_valid = 1'b0;
        end
        for (int t = 0; t < 8 && done_cnt == 0; t++) @(negedge clk);
        @(negedge clk);
        chk(done_cnt == 1, "R8", "write done pulses", done_cnt, 1);
        chk(exp_addr.size() == 0, tag, "write pixels left unvisited", exp_addr.size(), 0);
        chk(rd_busy == 1'b0, "R8", "rd_busy during write", rd_busy, 0);
        @(posedge clk); #1;
    endtask

    task automatic run_read(input string tag, input logic [31:0] pw, input logic [31:0] sw,
                            input int x0, input int y0, input int w, input int h);
        logic [15:0] pv[$];
        int n;
        int nw;
        int lat;
        logic [31:0] ew;
        n = w * h;
        nw = (n + 1) / 2;
        plan(x0, y0, w, h);
        for (int i = 0; i < n; i++) pv.push_back(mval(exp_addr[i]));
        done_cnt = 0;
        start_xfer(pw, sw, 1'b1);
        @(negedge clk);
        chk(rd_busy == 1'b1, "R7", "rd_busy after read start", rd_busy, 1);
        lat = 1;
        while (!rd_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat <= 4, "R7", "first word latency", lat, 4);
        for (int k = 0; k < nw; k++) begin
            while (!rd_valid) @(negedge clk);
            ew = {(2 * k + 1 < n) ? pv[2 * k + 1] : 16'h0000, pv[2 * k]};
            chk(rd_data == ew, "R5", "read word", rd_data, ew);
            @(posedge clk); #1;
            rd_pop = 1'b1;
            @(posedge clk); #1;
            rd_pop = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        chk(rd_busy == 1'b0, "R8", "rd_busy after last pop", rd_busy, 0);
        chk(done_cnt == 1, "R8", "read done pulses", done_cnt, 1);
        chk(exp_addr.size() == 0, tag, "read pixels left unvisited", exp_addr.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs low under reset
        chk({wr_ready, rd_valid, rd_busy, done, mem_en, mem_we} == 6'b0, "R9",
            "control outputs in reset", {wr_ready, rd_valid, rd_busy, done, mem_en, mem_we}, 0);
        chk(rd_data == 32'h0, "R9", "rd_data in reset", rd_data, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: no accesses while idle
        chk(mem_en == 1'b0, "R10", "idle access", mem_en, 0);

        // R1: junk in position bits 31:25 and 15:10; 4x2 at (10,20), junk in size too
        run_write("R1", 32'hFE14_FC0A, 32'hF002_7C04, 10, 20, 4, 2, 0, 16'h1000);
        // R6: odd 3x3 rectangle with stalls between words, pause lands mid-row
        run_write("R6", 32'h0007_0064, 32'h0003_0003, 100, 7, 3, 3, 2, 16'h2000);
        // R7: read back both rectangles, even and odd pixel counts
        run_read("R7", 32'h0014_000A, 32'h0002_0004, 10, 20, 4, 2);
        run_read("R5", 32'h0007_0064, 32'h0003_0003, 100, 7, 3, 3);
        // R3: height field 0 gives 512 rows; width field 0x401 gives 1; rows wrap past 511
        run_write("R3", 32'h01F4_0005, 32'h0000_0401, 5, 500, 1, 512, 0, 16'h3000);
        // R2: width field 0 gives 1024 pixels in one row
        run_write("R2", 32'h0003_0000, 32'h0001_0000, 0, 3, 1024, 1, 0, 16'h4000);
        // R4: column spill past X=1023 and row wrap at the last row
        run_write("R4", 32'h01FF_03FF, 32'h0002_0002, 1023, 511, 2, 2, 1, 16'h5000);
        run_read("R4", 32'h01FF_03FF, 32'h0002_0002, 1023, 511, 2, 2);
        // R10: nothing moves after completion
        repeat (3) @(negedge clk);
        chk(mem_en == 1'b0, "R10", "access after completion", mem_en, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule